// File: doc/BRIEF.md
# Load/Store-Multiple Beat Sequencer

This block walks a block register transfer over a 64-bit memory port. It takes a register list (one bit per register), a base byte address and a direction flag. It then issues one data beat per cycle until every listed register has been moved. Each beat has two 32-bit lanes, so one beat can carry two registers. Memory is assumed to accept every beat in the cycle it is offered. Base writeback, faults and extra stalls for the program counter are not handled here.

The main pipeline is held for only the first cycle of a transfer. After that, a dependency checker watches the pending-register mask. Each bit of that mask drops the cycle after the beat that carries its register, so a stall on that register can be released before the whole list is finished. A done pulse marks the end of each transfer, including a transfer with an empty list.

Top module: `lsm_beat_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy`, `mem_valid`, `done` and `exec_hold` are 0 and `reg_pending` is all zeros.
- R2: A `start` seen at a clock edge while `busy` is 0 is accepted. From the next cycle `reg_pending` equals `reg_list`. A `start` while `busy` is 1 has no effect on the pending mask, the addresses or the lanes.
- R3: Registers are moved in ascending register-number order. In a beat carrying two registers, the lower-numbered one is in the low lane (`mem_lane_en` bit 0, bytes addr+0..3) and the next one is in the high lane (bit 1, bytes addr+4..7).
- R4: With a 64-bit-aligned base, each beat carries two registers. An odd-length list ends with a beat that has only the low lane (`mem_lane_en` = 2'b01). The beat count is ceil(N/2), so lists of 2k-1 and 2k registers take the same number of beats.
- R5: When any of `base_addr` bits 2..0 is set, the first beat carries only the lowest register, in the high lane (`mem_lane_en` = 2'b10). The beat count becomes ceil((N+1)/2), one more than aligned when N is even.
- R6: Beats are offered in consecutive cycles, starting the cycle after acceptance. The first `mem_addr` is `base_addr` with bits 2..0 cleared, and the address rises by 8 per beat.
- R7: A register's bit in `reg_pending` stays set through the cycle of its beat and is clear from the next cycle.
- R8: `exec_hold` is 1 for exactly the one cycle after acceptance.
- R9: `done` pulses for one cycle, the cycle after the final beat, and is never high together with `mem_valid`. An empty list gives no beats and `done` the cycle after acceptance.
- R10: `mem_write` is the inverse of `is_load` as sampled at acceptance, and is held for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new transfer |
| reg_list | input | 16 | One bit per register to move |
| base_addr | input | 32 | Byte address of the lowest register |
| is_load | input | 1 | 1 = load, 0 = store |
| busy | output | 1 | Beats remain in the current transfer |
| exec_hold | output | 1 | Holds the main pipeline for the first cycle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| reg_pending | output | 16 | Registers not yet moved |
| mem_valid | output | 1 | A beat is offered this cycle |
| mem_write | output | 1 | Beat direction, 1 = write |
| mem_addr | output | 32 | 8-byte-aligned beat address |
| mem_lane_en | output | 2 | Lane enables: bit 0 low word, bit 1 high word |
| mem_reg_lo | output | 4 | Register number in the low lane |
| mem_reg_hi | output | 4 | Register number in the high lane |

## Verification
A remaining-register mask that loses or keeps the wrong bit shows up in `reg_pending` in the very next cycle. It also shows as a wrong lane register number on the following beat. An address counter that steps wrongly is exposed at the second beat. A misalignment flag that is not cleared gives a high-lane-only second beat and an extra beat. An off-by-one in the end condition moves `done` by a cycle or makes it overlap `mem_valid`. Each of these is visible within one or two cycles of the fault.

// File: rtl/lsm_beat_seq.sv
module lsm_beat_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NREG-1:0] reg_list,
  input  logic [AW-1:0]   base_addr,
  input  logic            is_load,
  output logic            busy,
  output logic            exec_hold,
  output logic            done,
  output logic [NREG-1:0] reg_pending,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_lane_en,
  output logic [IW-1:0]   mem_reg_lo,
  output logic [IW-1:0]   mem_reg_hi
);
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic            mis_q, wr_q, hold_q, done_q;
  logic [IW-1:0]   lo_idx, sec_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) lo_idx = IW'(i);
  end

  wire [NREG-1:0] lo_bit = NREG'(1) << lo_idx;
  wire [NREG-1:0] rest   = rem_q & ~lo_bit;

  always_comb begin
    sec_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rest[i]) sec_idx = IW'(i);
  end

  wire sec_ok = |rest;
  wire single = mis_q;
  wire [NREG-1:0] taken = (single || !sec_ok) ? lo_bit : (lo_bit | (NREG'(1) << sec_idx));
  wire [NREG-1:0] rem_nxt = rem_q & ~taken;
  wire accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
      mis_q  <= 1'b0;
      wr_q   <= 1'b0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      hold_q <= accept;
      done_q <= accept ? (reg_list == '0) : (busy && rem_nxt == '0);
      if (accept) begin
        rem_q  <= reg_list;
        addr_q <= {base_addr[AW-1:3], 3'b000};
        mis_q  <= |base_addr[2:0];
        wr_q   <= ~is_load;
      end else if (busy) begin
        rem_q  <= rem_nxt;
        addr_q <= addr_q + AW'(8);
        mis_q  <= 1'b0;
      end
    end
  end

  assign busy        = |rem_q;
  assign mem_valid   = busy;
  assign mem_addr    = addr_q;
  assign mem_write   = wr_q;
  assign mem_lane_en = !busy ? 2'b00 : (single ? 2'b10 : {sec_ok, 1'b1});
  assign mem_reg_lo  = lo_idx;
  assign mem_reg_hi  = single ? lo_idx : sec_idx;
  assign reg_pending = rem_q;
  assign exec_hold   = hold_q;
  assign done        = done_q;
endmodule

// File: rtl/lsm_beat_seq_chk.sv
module lsm_beat_seq_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            exec_hold,
  input logic            done,
  input logic [NREG-1:0] reg_pending,
  input logic            mem_valid,
  input logic [AW-1:0]   mem_addr,
  input logic [1:0]      mem_lane_en,
  input logic [IW-1:0]   mem_reg_lo,
  input logic [IW-1:0]   mem_reg_hi
);
  logic [NREG-1:0] bmask;
  assign bmask = (mem_lane_en[0] ? (NREG'(1) << mem_reg_lo) : '0) |
                 (mem_lane_en[1] ? (NREG'(1) << mem_reg_hi) : '0);

  a_r3_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_lane_en == 2'b11) |-> mem_reg_hi > mem_reg_lo);
  a_r6_dword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[2:0] == 3'b000 && mem_lane_en != 2'b00));
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid)) |-> mem_addr == $past(mem_addr) + AW'(8));
  a_r7_beat_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (reg_pending & bmask) == bmask);
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> (reg_pending & $past(bmask)) == '0);
  a_r2_no_new_bits: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (reg_pending & ~$past(reg_pending)) == '0);
  a_r8_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_hold |=> !exec_hold);
  a_r9_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_valid && !busy));
endmodule

bind lsm_beat_seq lsm_beat_seq_chk #(.NREG(NREG), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .exec_hold(exec_hold), .done(done),
  .reg_pending(reg_pending), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .mem_lane_en(mem_lane_en), .mem_reg_lo(mem_reg_lo), .mem_reg_hi(mem_reg_hi)
);

// File: tb/lsm_beat_seq_tb_top.sv
module lsm_beat_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic is_load = 1'b0;
  logic busy, exec_hold, done, mem_valid, mem_write;
  logic [15:0] reg_pending;
  logic [31:0] mem_addr;
  logic [1:0] mem_lane_en;
  logic [3:0] mem_reg_lo, mem_reg_hi;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lsm_beat_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
    .base_addr(base_addr), .is_load(is_load), .busy(busy), .exec_hold(exec_hold),
    .done(done), .reg_pending(reg_pending), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_lane_en(mem_lane_en),
    .mem_reg_lo(mem_reg_lo), .mem_reg_hi(mem_reg_hi)
  );

  localparam int NV = 10;
  localparam logic [15:0] V_LIST [NV] = '{16'h000F, 16'h0007, 16'h0003, 16'h0001, 16'hFFFF,
                                          16'hFFFF, 16'h8421, 16'h0100, 16'hA005, 16'h0000};
  localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h1000, 32'h2004, 32'h2004, 32'h0,
                                          32'h4, 32'h100, 32'h10, 32'h3C, 32'h0};
  localparam logic V_LD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam int V_BEATS [NV] = '{2, 2, 2, 1, 8, 9, 2, 1, 3, 0};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] lst, input logic [31:0] base, input logic ld, input int beats);
    int order [16];
    int n = 0;
    int idx = 0;
    logic [15:0] pend = lst;
    logic mis = base[2:0] != 3'b000;
    for (int i = 0; i < 16; i++) if (lst[i]) begin order[n] = i; n++; end
    @(negedge clk);
    start = 1'b1; reg_list = lst; base_addr = base; is_load = ld;
    @(negedge clk);
    start = 1'b0;
    chk(exec_hold == 1'b1, "R8 hold first cycle", 32'(exec_hold), 1);
    chk(reg_pending == lst, "R2 pending latched", 32'(reg_pending), 32'(lst));
    for (int b = 0; b < beats; b++) begin
      logic [1:0] en;
      int lo = 0;
      int hi = 0;
      if (b == 0 && mis) begin en = 2'b10; hi = order[0]; idx = 1; end
      else begin
        lo = order[idx];
        if (idx + 1 < n) begin en = 2'b11; hi = order[idx + 1]; idx += 2; end
        else begin en = 2'b01; idx += 1; end
      end
      chk(mem_valid == 1'b1, "R6 beat offered", 32'(mem_valid), 1);
      chk(mem_addr == {base[31:3], 3'b000} + 32'(8 * b), "R6 beat address", mem_addr,
          {base[31:3], 3'b000} + 32'(8 * b));
      chk(mem_lane_en == en, mis ? "R5 lanes" : "R4 lanes", 32'(mem_lane_en), 32'(en));
      if (en[0]) chk(mem_reg_lo == 4'(lo), "R3 low lane reg", 32'(mem_reg_lo), 32'(lo));
      if (en[1]) chk(mem_reg_hi == 4'(hi), "R3 high lane reg", 32'(mem_reg_hi), 32'(hi));
      chk(mem_write == !ld, "R10 direction", 32'(mem_write), 32'(!ld));
      chk(reg_pending == pend, "R7 pending during beat", 32'(reg_pending), 32'(pend));
      chk(done == 1'b0, "R9 no early done", 32'(done), 0);
      if (b == 1) chk(exec_hold == 1'b0, "R8 hold released", 32'(exec_hold), 0);
      if (en[0]) pend[lo] = 1'b0;
      if (en[1]) pend[hi] = 1'b0;
      @(negedge clk);
    end
    chk(done == 1'b1, "R9 done after last beat", 32'(done), 1);
    chk(mem_valid == 1'b0, mis ? "R5 beat count" : "R4 beat count", 32'(mem_valid), 0);
    chk(reg_pending == 16'h0, "R7 all released", 32'(reg_pending), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_valid == 1'b0, "R1 idle in reset", 32'({busy, mem_valid}), 0);
    chk(done == 1'b0 && exec_hold == 1'b0, "R1 quiet in reset", 32'({done, exec_hold}), 0);
    chk(reg_pending == 16'h0, "R1 pending clear", 32'(reg_pending), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", 32'({busy, done}), 0);

    for (int v = 0; v < NV; v++) run_vec(V_LIST[v], V_BASE[v], V_LD[v], V_BEATS[v]);

    // R2: a start while busy must not disturb the running transfer
    @(negedge clk);
    start = 1'b1; reg_list = 16'h00F0; base_addr = 32'h40; is_load = 1'b1;
    @(negedge clk);
    reg_list = 16'hFFFF; base_addr = 32'h4; is_load = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(reg_pending == 16'h00C0, "R2 busy start ignored", 32'(reg_pending), 32'h00C0);
    chk(mem_addr == 32'h48, "R2 address kept", mem_addr, 32'h48);
    chk(mem_reg_lo == 4'd6 && mem_reg_hi == 4'd7, "R2 lanes kept",
        32'({mem_reg_lo, mem_reg_hi}), 32'h67);
    chk(mem_write == 1'b0, "R10 direction kept", 32'(mem_write), 0);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R9 done after ignored start", 32'({done, busy}), 32'h2);

    // R1: reset during a transfer returns the block to idle
    @(negedge clk);
    start = 1'b1; reg_list = 16'hFFFF; base_addr = 32'h0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && mem_valid == 1'b0, "R1 reset mid transfer", 32'({busy, mem_valid}), 0);
    chk(reg_pending == 16'h0, "R1 pending after reset", 32'(reg_pending), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 no done after reset", 32'(done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule